// File: doc/BRIEF.md
# Buffered Timer Capture/Compare Channel

One 16-bit channel of a general-purpose timer that works either as a capture unit or as a compare unit. It watches two free-running time bases supplied by the surrounding timer: a primary count and a secondary count. When the timer runs the two as one cascaded 32-bit count, the secondary input carries the upper half. In capture mode, a selected edge on an asynchronous capture pin copies one time-base value into the main register and raises a one-cycle flag. Configuration decides which time base is copied.

In compare mode the main register holds the compare value that is in use. Software never writes it directly. It writes a shadow register, and the shadow is moved into the main register only when the selected time base wraps or is cleared to zero, so a period is never cut short by a new value. A one-cycle match output fires when the selected time base steps onto the main register value. A small word-wide register port gives access to the main register (read only), the shadow register and the control register.

Top module: `tmr_capcmp_channel`

## Requirements
- R1: After reset the main, shadow and control registers all read zero, and capFlag and cmpMatch are low.
- R2: Reads at address 0 return the main register, at address 1 the shadow register, at address 2 the control register (7 bits, zero-extended). A write to address 0 has no effect.
- R3: Control layout: bit 0 = mode (0 capture, 1 compare), bit 1 = buffer enable, bit 2 = source select (0 primary, 1 secondary), bits 4:3 = cascade select, bits 6:5 = edge select. With buffer enable clear and cascade select not 2'b11, the secondary time base is used whatever the source select bit holds.
- R4: With buffer enable set and cascade select not 2'b11, source select picks the primary (0) or secondary (1) time base.
- R5: With cascade select equal to 2'b11, the secondary input (upper 16 bits of the cascaded count) is used regardless of buffer enable and source select.
- R6: The capture pin passes through two flip-flops. Edge select 2'b01 takes rising edges, 2'b10 falling edges, 2'b11 both, and 2'b00 none. A pin change sampled at clock edge k updates the main register and capFlag at edge k+2, with the time-base value present just before edge k+2.
- R7: Each capture event raises capFlag for exactly the clock cycle that follows it.
- R8: In compare mode a write to the shadow register does not change the main register until a reload.
- R9: In compare mode, when the selected time base reads zero and read nonzero one cycle earlier, the next clock edge copies the shadow register into the main register.
- R10: When a shadow write and a reload occur in the same cycle, the main register takes the newly written value.
- R11: In compare mode cmpMatch is high in a cycle exactly when the selected time base differs from its value one cycle earlier and equals the main register.
- R12: In compare mode, capture pin edges neither change the main register nor raise capFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capIn | input | 1 | Asynchronous capture pin |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for addr |
| tbPri | input | 16 | Primary time base count |
| tbSec | input | 16 | Secondary time base count, or upper half when cascaded |
| mainValue | output | 16 | Live main register value |
| capFlag | output | 1 | One-cycle capture indication |
| cmpMatch | output | 1 | One-cycle compare match |

## Verification
Captures are taken with the two time bases held at distinct constant values, so the latched word shows which source was chosen under each setting of buffer enable, source select and cascade select. Pin toggles under each edge-select code, including "none" and a compare-mode setting, separate edge polarity handling from mode gating. In compare mode the secondary count is run through a wrap with a pending shadow value, once with a write on the exact reload cycle, which distinguishes reload timing and write precedence. The count then passes the compare value once, which pins down the single-cycle match.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int CTRL_W   = 7;
  localparam int ADDR_W   = 2;
  localparam int BIT_MODE = 0;
  localparam int BIT_BUF  = 1;
  localparam int BIT_SRC  = 2;
  localparam int CASC_LO  = 3;
  localparam int EDGE_LO  = 5;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MAIN   = 2'd0,
    ADDR_SHADOW = 2'd1,
    ADDR_CTRL   = 2'd2
  } ccc_addr_e;

  typedef struct packed {
    logic capLatch;
    logic reload;
    logic shadowWr;
    logic useSec;
    logic tbAdvanced;
    logic compareMode;
  } ccc_strobe_t;
endpackage

// File: rtl/ccc_ctrl.sv
module ccc_ctrl
  import ccc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] tbPri,
  input  logic [DATA_W-1:0] tbSec,
  output logic [CTRL_W-1:0] ctrlReg,
  output ccc_strobe_t       strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   capPrev;
  logic [DATA_W-1:0]      priPrev, secPrev, selNow, selPrev;
  logic                   riseEv, fallEv, useSec, isCompare;
  logic [1:0]             edgeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      capPrev <= 1'b0;
      ctrlReg <= '0;
      priPrev <= '0;
      secPrev <= '0;
    end else begin
      syncQ   <= {syncQ[LAST-1:0], capIn};
      capPrev <= syncQ[LAST];
      priPrev <= tbPri;
      secPrev <= tbSec;
      if (wrEn && addr == ADDR_CTRL) ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  assign isCompare = ctrlReg[BIT_MODE];
  assign edgeSel   = ctrlReg[EDGE_LO +: 2];
  assign useSec    = (ctrlReg[CASC_LO +: 2] == 2'b11) || !ctrlReg[BIT_BUF] || ctrlReg[BIT_SRC];
  assign selNow    = useSec ? tbSec : tbPri;
  assign selPrev   = useSec ? secPrev : priPrev;
  assign riseEv    = syncQ[LAST] && !capPrev;
  assign fallEv    = !syncQ[LAST] && capPrev;

  always_comb begin
    strb             = '0;
    strb.compareMode = isCompare;
    strb.useSec      = useSec;
    strb.capLatch    = !isCompare && ((edgeSel[0] && riseEv) || (edgeSel[1] && fallEv));
    strb.reload      = isCompare && (selNow == '0) && (selPrev != '0);
    strb.shadowWr    = wrEn && (addr == ADDR_SHADOW);
    strb.tbAdvanced  = (selNow != selPrev);
  end

  p_edge_seen_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLatch |-> (syncQ[LAST] != capPrev));
  p_no_cap_in_cmp_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[BIT_MODE] |-> !strb.capLatch);
  p_reload_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reload && useSec && $past(useSec)) |-> ($past(tbSec) != '0 && tbSec == '0));
endmodule

// File: rtl/ccc_datapath.sv
module ccc_datapath
  import ccc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccc_strobe_t       strb,
  input  logic [DATA_W-1:0] tbPri,
  input  logic [DATA_W-1:0] tbSec,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] mainReg,
  output logic [DATA_W-1:0] shadowReg,
  output logic              capFlag,
  output logic              cmpMatch
);
  logic [DATA_W-1:0] selTb;

  assign selTb = strb.useSec ? tbSec : tbPri;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainReg   <= '0;
      shadowReg <= '0;
      capFlag   <= 1'b0;
    end else begin
      capFlag <= strb.capLatch;
      if (strb.shadowWr) shadowReg <= wrData;
      if (strb.capLatch) mainReg <= selTb;
      else if (strb.reload) mainReg <= strb.shadowWr ? wrData : shadowReg;
    end
  end

  assign cmpMatch = strb.compareMode && strb.tbAdvanced && (selTb == mainReg);

  p_main_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capLatch && !strb.reload) |=> $stable(mainReg));
  p_reload_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reload && !strb.shadowWr) |=> (mainReg == $past(shadowReg)));
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reload && strb.shadowWr) |=> (mainReg == $past(wrData)));
  p_flag_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLatch |=> (capFlag && mainReg == $past(selTb)));
  p_match_mode_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmpMatch |-> !capFlag);
endmodule

// File: rtl/tmr_capcmp_channel.sv
module tmr_capcmp_channel
  import ccc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capIn,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] tbPri,
  input  logic [DATA_W-1:0] tbSec,
  output logic [DATA_W-1:0] mainValue,
  output logic              capFlag,
  output logic              cmpMatch
);
  ccc_strobe_t       strb;
  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] mainReg, shadowReg;

  ccc_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .capIn(capIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .tbPri(tbPri), .tbSec(tbSec), .ctrlReg(ctrlReg), .strb(strb)
  );

  ccc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tbPri(tbPri), .tbSec(tbSec),
    .wrData(wrData), .mainReg(mainReg), .shadowReg(shadowReg),
    .capFlag(capFlag), .cmpMatch(cmpMatch)
  );

  always_comb begin
    case (addr)
      ADDR_MAIN:   rdData = mainReg;
      ADDR_SHADOW: rdData = shadowReg;
      ADDR_CTRL:   rdData = DATA_W'(ctrlReg);
      default:     rdData = '0;
    endcase
  end

  assign mainValue = mainReg;
endmodule

// File: tb/tmr_capcmp_channel_test.sv
`timescale 1ns/1ps
module tmr_capcmp_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wrData = '0;
  logic [15:0] tbPri = '0;
  logic [15:0] tbSec = '0;
  logic [15:0] rdData, mainValue;
  logic        capFlag, cmpMatch;

  int checks = 0;
  int failures = 0;
  int matchCount = 0;
  int flagCount = 0;
  bit running = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;

  tmr_capcmp_channel uut (
    .clk(clk), .rstN(rstN), .capIn(capIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tbPri(tbPri), .tbSec(tbSec),
    .mainValue(mainValue), .capFlag(capFlag), .cmpMatch(cmpMatch)
  );

  // behavioural reference
  logic        pinHist[$] = '{1'b0, 1'b0, 1'b0};
  logic [15:0] mMain = '0, mShadow = '0, mPriOld = '0, mSecOld = '0;
  logic [6:0]  mCtrl = '0;
  logic        mFlag = 1'b0;

  function automatic bit pickSec(input logic [6:0] c);
    return (c[4:3] == 2'b11) || (c[1] == 1'b0) || (c[2] == 1'b1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMain = '0; mShadow = '0; mCtrl = '0; mFlag = 1'b0;
      mPriOld = '0; mSecOld = '0;
      pinHist = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit sec, up, down, ev, rl, sw;
      logic [15:0] cur, old;
      sec  = pickSec(mCtrl);
      cur  = sec ? tbSec : tbPri;
      old  = sec ? mSecOld : mPriOld;
      up   = pinHist[1] && !pinHist[2];
      down = !pinHist[1] && pinHist[2];
      ev   = !mCtrl[0] && ((mCtrl[5] && up) || (mCtrl[6] && down));
      rl   = mCtrl[0] && cur == 16'h0 && old != 16'h0;
      sw   = wrEn && addr == 2'd1;
      if (ev) mMain = cur;
      else if (rl) mMain = sw ? wrData : mShadow;
      mFlag = ev;
      if (sw) mShadow = wrData;
      if (wrEn && addr == 2'd2) mCtrl = wrData[6:0];
      mPriOld = tbPri;
      mSecOld = tbSec;
      pinHist.push_front(capIn);
      void'(pinHist.pop_back());
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      bit sec;
      logic [15:0] cur, old, rdExp;
      sec = pickSec(mCtrl);
      cur = sec ? tbSec : tbPri;
      old = sec ? mSecOld : mPriOld;
      rdExp = (addr == 2'd0) ? mMain : (addr == 2'd1) ? mShadow :
              (addr == 2'd2) ? {9'd0, mCtrl} : 16'h0;
      check(curReq, mainValue, mMain);
      check(curReq, {15'd0, capFlag}, {15'd0, mFlag});
      check(curReq, {15'd0, cmpMatch}, {15'd0, (mCtrl[0] && cur != old && cur == mMain)});
      check(curReq, rdData, rdExp);
      if (cmpMatch) matchCount++;
      if (capFlag) flagCount++;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      wrEn = 1'b0;
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; addr = 2'd0;
  endtask

  task automatic toggleCap(input int hold = 4);
    capIn = ~capIn;
    step(hold);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    running = 1'b1;
    // R1 reset state
    curReq = "R1";
    addr = 2'd0; step(1); check("R1 main", rdData, 16'h0);
    addr = 2'd1; step(1); check("R1 shadow", rdData, 16'h0);
    addr = 2'd2; step(1); check("R1 ctrl", rdData, 16'h0);
    check("R1 flags", {14'd0, capFlag, cmpMatch}, 16'h0);
    // R2 main is read only
    curReq = "R2";
    regWrite(2'd0, 16'hBEEF);
    addr = 2'd0; step(1); check("R2 main write ignored", rdData, 16'h0);
    // R3 buffer disabled selects secondary even with source select 0
    curReq = "R3";
    tbPri = 16'h0ABC; tbSec = 16'h5A5A;
    regWrite(2'd2, 16'h0020);
    addr = 2'd2; step(1); check("R3 ctrl readback", rdData, 16'h0020);
    toggleCap(5);
    check("R3 secondary captured", mainValue, 16'h5A5A);
    // R6 rising-only ignores falling edge
    curReq = "R6";
    tbSec = 16'h1111;
    toggleCap(5);
    check("R6 falling ignored", mainValue, 16'h5A5A);
    // R4 buffer enabled, source primary, both edges
    curReq = "R4";
    regWrite(2'd2, 16'h0062);
    toggleCap(5);
    check("R4 primary captured", mainValue, 16'h0ABC);
    regWrite(2'd2, 16'h0066);
    tbSec = 16'h1234;
    toggleCap(5);
    check("R4 secondary captured", mainValue, 16'h1234);
    // R7 one-cycle flag timing across fast toggles
    curReq = "R7";
    flagCount = 0;
    capIn = ~capIn; step(1);
    capIn = ~capIn; step(5);
    check("R7 two flags for two edges", 16'(flagCount), 16'd2);
    // R6 edge select none
    curReq = "R6";
    regWrite(2'd2, 16'h0002);
    tbPri = 16'h0F0F;
    toggleCap(5); toggleCap(5);
    check("R6 no edge selected", mainValue, 16'h1234);
    // R5 cascade overrides source select
    curReq = "R5";
    regWrite(2'd2, 16'h003A);
    tbSec = 16'h7777;
    toggleCap(5);
    check("R5 upper half captured", mainValue, 16'h7777);
    // R8 compare mode, shadow write held back
    curReq = "R8";
    regWrite(2'd2, 16'h0061);
    regWrite(2'd1, 16'h0005);
    step(2);
    check("R8 main unchanged", mainValue, 16'h7777);
    // R12 captures ignored in compare mode
    curReq = "R12";
    flagCount = 0;
    toggleCap(5); toggleCap(5);
    check("R12 main kept", mainValue, 16'h7777);
    check("R12 no flag", 16'(flagCount), 16'd0);
    // R9 reload on wrap of secondary, then R11 single match
    curReq = "R9";
    matchCount = 0;
    tbSec = 16'hFFFD;
    for (int i = 0; i < 4; i++) begin step(1); tbSec = tbSec + 16'd1; end
    step(2);
    check("R9 reloaded", mainValue, 16'h0005);
    curReq = "R11";
    for (int i = 0; i < 9; i++) begin step(1); tbSec = tbSec + 16'd1; end
    step(2);
    check("R11 one match", 16'(matchCount), 16'd1);
    // R10 write on the reload cycle wins
    curReq = "R10";
    regWrite(2'd1, 16'h0009);
    @(posedge clk); #1;
    tbSec = 16'h0000; wrEn = 1'b1; addr = 2'd1; wrData = 16'h0042;
    step(3);
    check("R10 new value loaded", mainValue, 16'h0042);
    addr = 2'd1; step(1);
    check("R10 shadow holds new", rdData, 16'h0042);
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule